// File: doc/BRIEF.md
# Coprocessor Operand Wrap-Around Checker

This block examines one multi-byte coprocessor memory operand before it is transferred. It reports where the operand's first and last bytes land once addresses fold at the addressing limit. It also raises a flag that asks for the coprocessor segment-overrun exception. The addressing limit is 0xFFFF for a small segment and 0xFFFFFFFF for a big one. An operand that runs past that limit continues from address zero, so its two ends sit at opposite ends of the segment.

The overrun flag is raised only in protected mode, and only when both end bytes are legal. A legal end byte lies inside the segment and in a page that is both present and accessible. Even with legal ends, the operand may still cover a byte that is not legal, for one of two reasons. The fold may carry it across addresses outside the segment. This happens with a limit below the addressing limit, and always with an expand-down segment, because offset zero is never inside an expand-down segment. Or the operand may cross a page boundary, and the page unit may report its interior page as not present or not accessible.

Requests enter on a valid/ready port and results leave from a registered valid/ready port. The input is ready whenever the result register is empty or is being drained in the same cycle. While the consumer holds its ready low, a pending result is held unchanged and no new request is taken. Back-pressure therefore reaches the requester after a single stalled result.

Top module: `owc_overrun_check`

## Requirements
- R1: `rsp_first` equals the request offset masked to the addressing limit: the low 16 bits when `req_big` is 0, all 32 bits when it is 1.
- R2: `rsp_last` equals (first + length − 1) modulo (addressing limit + 1). `req_len` encodes the length: 0 means 2 bytes, 1 means 4, 2 means 8 and 3 means 10.
- R3: `rsp_wraps` is 1 exactly when first + length − 1 exceeds the addressing limit.
- R4: For an expand-up segment (`req_expand_down` = 0), an address is inside the segment when it is at most the limit masked to the addressing limit. For an expand-down segment, an address is inside when it is above that masked limit.
- R5: `rsp_overrun` is 0 unless first and last are both inside the segment and page slots 0 (first byte) and 2 (last byte) both have their present bit and their access bit set.
- R6: With legal ends, `rsp_overrun` is 1 when the operand wraps and either the segment is expand-down or its masked limit is below the addressing limit.
- R7: With legal ends, `rsp_overrun` is 1 when the page numbers (address bits 31:12) of first and last differ and page slot 1 lacks its present bit or its access bit.
- R8: When `req_prot` is 0 (real mode), `rsp_overrun` is 0.
- R9: `req_ready` = !`rsp_valid` || `rsp_ready`. An accepted request sets `rsp_valid` with its result on the next clock edge. A result drained with no new request leaves `rsp_valid` low.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, every result output stays unchanged.
- R11: After reset, `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_offset | input | 32 | Starting offset of the operand |
| req_len | input | 2 | Operand length code (2/4/8/10 bytes) |
| req_limit | input | 32 | Segment limit |
| req_big | input | 1 | 1: 32-bit addressing limit, 0: 16-bit |
| req_expand_down | input | 1 | Segment grows downward |
| req_prot | input | 1 | Protected mode active |
| req_pg_present | input | 3 | Present bits: slot 0 first page, slot 1 interior page, slot 2 last page |
| req_pg_access | input | 3 | Access-right bits, same slots |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_first | output | 32 | First byte address after masking |
| rsp_last | output | 32 | Last byte address after wrap-around |
| rsp_wraps | output | 1 | Operand folds past the addressing limit |
| rsp_overrun | output | 1 | Segment-overrun exception requested |

## Verification
The result register can be drained and reloaded in the same clock edge. This happens when a stalled result is released while the next request is already waiting. The bench provokes it by holding `rsp_ready` low across two cycles with a second request on the input. It then raises `rsp_ready` and checks three things: `req_ready` rises in the same cycle, `rsp_valid` stays high through the edge, and the outputs switch directly from the first result to the second. It also checks that the first result was unchanged throughout the stall.

// File: rtl/owc_pkg.sv
package owc_pkg;

  typedef enum logic [1:0] {
    OPLEN_2  = 2'd0,
    OPLEN_4  = 2'd1,
    OPLEN_8  = 2'd2,
    OPLEN_10 = 2'd3
  } oplen_e;

  localparam int unsigned SPAN_W = 4;

  function automatic logic [SPAN_W-1:0] oplen_span(oplen_e sel);
    case (sel)
      OPLEN_2:  oplen_span = 4'd1;
      OPLEN_4:  oplen_span = 4'd3;
      OPLEN_8:  oplen_span = 4'd7;
      default:  oplen_span = 4'd9;
    endcase
  endfunction

endpackage

// File: rtl/owc_span.sv
module owc_span #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned SMALL_W = 16
) (
  input  logic [ADDR_W-1:0]  offset,
  input  owc_pkg::oplen_e    len_sel,
  input  logic               big,
  output logic [ADDR_W-1:0]  addr_max,
  output logic [ADDR_W-1:0]  first,
  output logic [ADDR_W-1:0]  last,
  output logic               wraps
);
  localparam int unsigned PAD_W = ADDR_W + 1 - owc_pkg::SPAN_W;

  logic [ADDR_W:0] sum;

  assign addr_max = big ? {ADDR_W{1'b1}}
                        : {{(ADDR_W-SMALL_W){1'b0}}, {SMALL_W{1'b1}}};
  assign first    = offset & addr_max;
  assign sum      = {1'b0, first} + {{PAD_W{1'b0}}, owc_pkg::oplen_span(len_sel)};
  // a masked small-segment start is below 2^SMALL_W, so that bit is the carry
  assign wraps    = big ? sum[ADDR_W] : sum[SMALL_W];
  assign last     = sum[ADDR_W-1:0] & addr_max;

endmodule

// File: rtl/owc_judge.sv
module owc_judge #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned PAGE_SHIFT = 12
) (
  input  logic [ADDR_W-1:0] first,
  input  logic [ADDR_W-1:0] last,
  input  logic [ADDR_W-1:0] addr_max,
  input  logic              wraps,
  input  logic [ADDR_W-1:0] seg_limit,
  input  logic              expand_down,
  input  logic              prot,
  input  logic [2:0]        pg_present,
  input  logic [2:0]        pg_access,
  output logic              overrun
);
  logic [ADDR_W-1:0] lim;
  logic [ADDR_W-1:0] ends [2];
  logic [1:0]        end_in;
  logic [2:0]        pg_ok;
  logic              ends_ok, seg_gap, page_cross, page_gap;

  assign lim     = seg_limit & addr_max;
  assign ends[0] = first;
  assign ends[1] = last;

  for (genvar e = 0; e < 2; e++) begin : g_end
    assign end_in[e] = expand_down ? (ends[e] > lim) : (ends[e] <= lim);
  end

  assign pg_ok      = pg_present & pg_access;
  assign ends_ok    = &end_in & pg_ok[0] & pg_ok[2];
  // folding through zero leaves an expand-down segment; an expand-up one is
  // left only when its limit stops short of the addressing limit
  assign seg_gap    = wraps & (expand_down | (lim != addr_max));
  assign page_cross = first[ADDR_W-1:PAGE_SHIFT] != last[ADDR_W-1:PAGE_SHIFT];
  assign page_gap   = page_cross & ~pg_ok[1];
  assign overrun    = prot & ends_ok & (seg_gap | page_gap);

endmodule

// File: rtl/owc_overrun_check.sv
module owc_overrun_check #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned SMALL_W    = 16,
  parameter int unsigned PAGE_SHIFT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_offset,
  input  logic [1:0]        req_len,
  input  logic [ADDR_W-1:0] req_limit,
  input  logic              req_big,
  input  logic              req_expand_down,
  input  logic              req_prot,
  input  logic [2:0]        req_pg_present,
  input  logic [2:0]        req_pg_access,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_first,
  output logic [ADDR_W-1:0] rsp_last,
  output logic              rsp_wraps,
  output logic              rsp_overrun
);
  logic [ADDR_W-1:0] c_max, c_first, c_last;
  logic              c_wraps, c_overrun, accept;

  owc_span #(.ADDR_W(ADDR_W), .SMALL_W(SMALL_W)) u_span (
    .offset   (req_offset),
    .len_sel  (owc_pkg::oplen_e'(req_len)),
    .big      (req_big),
    .addr_max (c_max),
    .first    (c_first),
    .last     (c_last),
    .wraps    (c_wraps)
  );

  owc_judge #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) u_judge (
    .first       (c_first),
    .last        (c_last),
    .addr_max    (c_max),
    .wraps       (c_wraps),
    .seg_limit   (req_limit),
    .expand_down (req_expand_down),
    .prot        (req_prot),
    .pg_present  (req_pg_present),
    .pg_access   (req_pg_access),
    .overrun     (c_overrun)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_first   <= '0;
      rsp_last    <= '0;
      rsp_wraps   <= 1'b0;
      rsp_overrun <= 1'b0;
    end else if (accept) begin
      rsp_valid   <= 1'b1;
      rsp_first   <= c_first;
      rsp_last    <= c_last;
      rsp_wraps   <= c_wraps;
      rsp_overrun <= c_overrun;
    end else if (rsp_ready) begin
      rsp_valid   <= 1'b0;
    end
  end

endmodule

// File: rtl/owc_overrun_sva.sv
module owc_overrun_sva #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_prot,
  input logic [2:0]        req_pg_present,
  input logic [2:0]        req_pg_access,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [ADDR_W-1:0] rsp_first,
  input logic [ADDR_W-1:0] rsp_last,
  input logic              rsp_wraps,
  input logic              rsp_overrun
);
  assert_blocked_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  assert_load_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  assert_empty_after_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready && !req_valid) |=> !rsp_valid);

  assert_hold_under_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_first) && $stable(rsp_last)
                                   && $stable(rsp_wraps) && $stable(rsp_overrun)));

  assert_real_mode_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_prot) |=> !rsp_overrun);

  assert_first_page_needed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !(req_pg_present[0] && req_pg_access[0])) |=> !rsp_overrun);

endmodule

bind owc_overrun_check owc_overrun_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .req_prot       (req_prot),
  .req_pg_present (req_pg_present),
  .req_pg_access  (req_pg_access),
  .rsp_valid      (rsp_valid),
  .rsp_ready      (rsp_ready),
  .rsp_first      (rsp_first),
  .rsp_last       (rsp_last),
  .rsp_wraps      (rsp_wraps),
  .rsp_overrun    (rsp_overrun)
);

// File: tb/owc_overrun_check_test.sv
`timescale 1ns/1ps
module owc_overrun_check_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_offset = '0;
  logic [1:0]  req_len = '0;
  logic [31:0] req_limit = '0;
  logic        req_big = 1'b0;
  logic        req_expand_down = 1'b0;
  logic        req_prot = 1'b0;
  logic [2:0]  req_pg_present = '0;
  logic [2:0]  req_pg_access = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_first, rsp_last;
  logic        rsp_wraps, rsp_overrun;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  owc_overrun_check uut (.*);

  // {offset, limit, len, big, xdown, prot, present, access, first, last, wraps, overrun}
  localparam logic [140:0] VEC [13] = '{
    // R6: small limit stops short of 0xFFFF
    {32'h0000FFFC, 32'h0000FFFD, 2'd2, 1'b0, 1'b0, 1'b1, 3'b111, 3'b111, 32'h0000FFFC, 32'h00000003, 1'b1, 1'b1},
    // R6: full small segment, no gap
    {32'h0000FFFC, 32'h0000FFFF, 2'd2, 1'b0, 1'b0, 1'b1, 3'b111, 3'b111, 32'h0000FFFC, 32'h00000003, 1'b1, 1'b0},
    // R7: interior page not present
    {32'h0000FFFC, 32'h0000FFFF, 2'd2, 1'b0, 1'b0, 1'b1, 3'b101, 3'b111, 32'h0000FFFC, 32'h00000003, 1'b1, 1'b1},
    // R8: real mode
    {32'h0000FFFC, 32'h0000FFFD, 2'd2, 1'b0, 1'b0, 1'b0, 3'b111, 3'b111, 32'h0000FFFC, 32'h00000003, 1'b1, 1'b0},
    // R2 R3: plain operand
    {32'h00001000, 32'h0000FFFF, 2'd1, 1'b0, 1'b0, 1'b1, 3'b111, 3'b111, 32'h00001000, 32'h00001003, 1'b0, 1'b0},
    // R4 R5: first byte beyond limit
    {32'h0000FFFE, 32'h0000FFFD, 2'd1, 1'b0, 1'b0, 1'b1, 3'b111, 3'b111, 32'h0000FFFE, 32'h00000001, 1'b1, 1'b0},
    // R7: big segment, interior page not accessible
    {32'hFFFFFFFA, 32'hFFFFFFFF, 2'd3, 1'b1, 1'b0, 1'b1, 3'b111, 3'b101, 32'hFFFFFFFA, 32'h00000003, 1'b1, 1'b1},
    // R3: big segment fold, all legal
    {32'hFFFFFFFA, 32'hFFFFFFFF, 2'd3, 1'b1, 1'b0, 1'b1, 3'b111, 3'b111, 32'hFFFFFFFA, 32'h00000003, 1'b1, 1'b0},
    // R4: expand-down, no fold
    {32'h0000FFFE, 32'h000000FF, 2'd0, 1'b0, 1'b1, 1'b1, 3'b111, 3'b111, 32'h0000FFFE, 32'h0000FFFF, 1'b0, 1'b0},
    // R6: expand-down fold passes zero
    {32'h0000FFFE, 32'h00000000, 2'd2, 1'b0, 1'b1, 1'b1, 3'b111, 3'b111, 32'h0000FFFE, 32'h00000005, 1'b1, 1'b1},
    // R1: upper offset bits dropped in a small segment
    {32'h12340010, 32'h0000FFFF, 2'd0, 1'b0, 1'b0, 1'b1, 3'b111, 3'b111, 32'h00000010, 32'h00000011, 1'b0, 1'b0},
    // R7: page crossing without fold, interior denied
    {32'h00000FFE, 32'h0000FFFF, 2'd1, 1'b0, 1'b0, 1'b1, 3'b111, 3'b101, 32'h00000FFE, 32'h00001001, 1'b0, 1'b1},
    // R5: last page not present
    {32'h0000FFFC, 32'h0000FFFD, 2'd2, 1'b0, 1'b0, 1'b1, 3'b011, 3'b111, 32'h0000FFFC, 32'h00000003, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [140:0] v);
    {req_offset, req_limit, req_len, req_big, req_expand_down, req_prot,
     req_pg_present, req_pg_access} = v[140:66];
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected below 20000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);
    chk("R11 req_ready after reset", {31'b0, req_ready}, 32'd1);

    for (int i = 0; i < 13; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R9 rsp_valid after accept", {31'b0, rsp_valid}, 32'd1);
      chk("R1 first", rsp_first, VEC[i][65:34]);
      chk("R2 last", rsp_last, VEC[i][33:2]);
      chk("R3 wraps", {31'b0, rsp_wraps}, {31'b0, VEC[i][1]});
      chk("overrun R4 R5 R6 R7 R8", {31'b0, rsp_overrun}, {31'b0, VEC[i][0]});
    end
    @(negedge clk);
    chk("R9 empty after drain", {31'b0, rsp_valid}, 32'd0);

    // stall, then drain and reload on one edge
    rsp_ready = 1'b0;
    drive(VEC[4]);
    req_valid = 1'b1;
    @(negedge clk);
    drive(VEC[0]);
    chk("R9 stalled result valid", {31'b0, rsp_valid}, 32'd1);
    chk("R9 input blocked while full", {31'b0, req_ready}, 32'd0);
    chk("R10 first before stall edge", rsp_first, 32'h00001000);
    @(negedge clk);
    chk("R10 first held", rsp_first, 32'h00001000);
    chk("R10 last held", rsp_last, 32'h00001003);
    chk("R10 overrun held", {31'b0, rsp_overrun}, 32'd0);
    rsp_ready = 1'b1;
    #0.1;
    chk("R9 ready follows consumer", {31'b0, req_ready}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 valid through reload", {31'b0, rsp_valid}, 32'd1);
    chk("R9 reloaded first", rsp_first, 32'h0000FFFC);
    chk("R6 reloaded overrun", {31'b0, rsp_overrun}, 32'd1);
    @(negedge clk);
    chk("R9 drained", {31'b0, rsp_valid}, 32'd0);

    // reset while a result is pending
    rsp_ready = 1'b0;
    drive(VEC[0]);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R11 valid cleared by reset", {31'b0, rsp_valid}, 32'd0);
    chk("R11 overrun cleared by reset", {31'b0, rsp_overrun}, 32'd0);

    finish_run();
  end

endmodule